// File: doc/BRIEF.md
# Scratchpad Erase and Match Engine

This block is the command engine behind a 32-byte scratchpad that holds a 160-bit message authentication code together with three status flags: a hide flag, an authorisation flag and a match flag. A serial bus front end hands it command codes and data bytes that are already decoded. On every read slot the block returns one bit to that front end. A test port preloads scratchpad bytes and the hide and authorisation flags, and it can read back any byte.

The block handles two commands. The erase command fills every scratchpad byte with FFh and then clears the hide flag. The match command compares 20 bytes from the bus master against the MAC stored in the scratchpad. The comparison happens inside the block, so a hidden MAC never leaves it. The master reads an alternating bit pattern when a command completes or a comparison succeeds. It reads all ones while a command is still busy, after a failed comparison, and when no command is active. A bus reset input abandons the current command and keeps the stored state.

Top module: `scrpad_engine`

## Requirements
- R1: After rstN the hide, authorisation and match flags read 0, every scratchpad byte reads 00h, minReadMet is 0 and a read slot returns 1.
- R2: Command code C3h (erase) takes exactly two further data bytes as an address, which is ignored. After the fill, all 32 scratchpad bytes read FFh.
- R3: When the erase fill completes, hideFlag reads 0.
- R4: The fill lasts FILL_CYCLES = CLK_MHZ*FILL_US clock cycles after the second address byte. Every read slot in that time returns 1.
- R5: Once the fill has completed, successive read slots return 0,1,0,1,... starting with 0. readBit shows the result in the cycle after the readSlot strobe.
- R6: Command code 3Ch (match) takes 20 data bytes and compares them in order with scratchpad bytes 8 to 27. If all 20 are equal, read slots then return 0,1,0,1,... starting with 0.
- R7: If any of the 20 bytes differs, including only the first or only the last, every later read slot returns 1. All 20 bytes are still consumed, and bytes after them are ignored.
- R8: A full match sets matchFlag only when authFlag is 1. A failed match, or a full match with authFlag 0, leaves matchFlag unchanged.
- R9: minReadMet goes to 1 once 8 pattern bits have been read and stays 1 until the next bus reset. It stays 0 after fewer than 8 pattern reads and after a failed match.
- R10: busReset returns the engine to idle at once and clears the pattern count (minReadMet 0). The flags and scratchpad contents are kept, including during an erase that is still receiving its address bytes.
- R11: Any command code other than C3h and 3Ch is ignored. Any command code that arrives while a command is active is also ignored.
- R12: A match command changes neither the scratchpad contents nor hideFlag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| busReset | input | 1 | Bus reset strobe: abandon the command, go idle |
| cmdValid | input | 1 | Command code strobe |
| cmdCode | input | 8 | Decoded command code |
| dataValid | input | 1 | Data byte strobe |
| dataByte | input | 8 | Data byte from the master |
| readSlot | input | 1 | Read slot request strobe |
| readBit | output | 1 | Bit returned for the last read slot |
| loadEn | input | 1 | Test port scratchpad write strobe |
| loadAddr | input | 5 | Test port write byte index |
| loadData | input | 8 | Test port write data |
| flagWr | input | 1 | Test port flag write strobe |
| hideIn | input | 1 | Hide flag value to load |
| authIn | input | 1 | Authorisation flag value to load |
| peekAddr | input | 5 | Test port read byte index |
| peekData | output | 8 | Scratchpad byte at peekAddr |
| hideFlag | output | 1 | Hide flag |
| authFlag | output | 1 | Authorisation flag |
| matchFlag | output | 1 | Match flag |
| minReadMet | output | 1 | At least 8 completion-pattern bits read since last bus reset |

## Verification
The assertions assume that the strobes are single-cycle pulses aligned to the clock. They also assume that the test port does not write the hide flag in the same cycle as an erase completes, and that data bytes are offered only after a command code. The bench drives each strobe for exactly one cycle. It uses the test port only between commands, and it sends read slots only after the command bytes have been accepted. This keeps the stimulus inside those assumptions.

// File: rtl/scrpad_pkg.sv
package scrpad_pkg;
  localparam int SP_BYTES  = 32;
  localparam int MAC_BASE  = 8;
  localparam int MAC_BYTES = 20;
  localparam int MIN_READS = 8;
  localparam logic [7:0] ERASE_CODE = 8'hC3;
  localparam logic [7:0] MATCH_CODE = 8'h3C;
  localparam int AW = $clog2(SP_BYTES);
  localparam int MW = $clog2(MAC_BYTES);
  localparam int CW = $clog2(MIN_READS + 1);

  typedef enum logic [2:0] {
    ST_IDLE, ST_ERADDR, ST_FILL, ST_MATCHRX, ST_DONE
  } state_t;

  typedef struct packed {
    logic          fillWr;
    logic [AW-1:0] fillIdx;
    logic          cmpEn;
    logic [MW-1:0] cmpIdx;
    logic          cmpLast;
    logic          eraseDone;
    logic          patClr;
    logic          patActive;
  } ctl_t;
endpackage

// File: rtl/scrpad_ctrl.sv
module scrpad_ctrl
  import scrpad_pkg::*;
#(
  parameter int FILL_CYCLES = 1600
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       busReset,
  input  logic       cmdValid,
  input  logic [7:0] cmdCode,
  input  logic       dataValid,
  output ctl_t       ctl
);
  localparam int FW = $clog2(FILL_CYCLES + 1);

  state_t        state, stateNext;
  logic [MW-1:0] byteCnt, byteCntNext;
  logic [FW-1:0] fillCnt, fillCntNext;
  logic          cmdKnown;

  assign cmdKnown = (cmdCode == ERASE_CODE) || (cmdCode == MATCH_CODE);

  always_comb begin
    stateNext   = state;
    byteCntNext = byteCnt;
    fillCntNext = fillCnt;
    ctl         = '0;
    if (busReset) begin
      stateNext   = ST_IDLE;
      byteCntNext = '0;
      fillCntNext = '0;
      ctl.patClr  = 1'b1;
    end else begin
      case (state)
        ST_IDLE: begin
          if (cmdValid && cmdKnown) begin
            ctl.patClr  = 1'b1;
            byteCntNext = '0;
            stateNext   = (cmdCode == ERASE_CODE) ? ST_ERADDR : ST_MATCHRX;
          end
        end
        ST_ERADDR: begin
          if (dataValid) begin
            if (byteCnt == MW'(1)) begin
              stateNext   = ST_FILL;
              fillCntNext = '0;
            end else begin
              byteCntNext = byteCnt + MW'(1);
            end
          end
        end
        ST_FILL: begin
          ctl.fillWr  = (fillCnt < FW'(SP_BYTES));
          ctl.fillIdx = AW'(fillCnt);
          if (fillCnt == FW'(FILL_CYCLES - 1)) begin
            ctl.eraseDone = 1'b1;
            stateNext     = ST_DONE;
          end else begin
            fillCntNext = fillCnt + FW'(1);
          end
        end
        ST_MATCHRX: begin
          if (dataValid) begin
            ctl.cmpEn  = 1'b1;
            ctl.cmpIdx = byteCnt;
            if (byteCnt == MW'(MAC_BYTES - 1)) begin
              ctl.cmpLast = 1'b1;
              stateNext   = ST_DONE;
            end else begin
              byteCntNext = byteCnt + MW'(1);
            end
          end
        end
        ST_DONE:  ctl.patActive = 1'b1;
        default:  stateNext = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      byteCnt <= '0;
      fillCnt <= '0;
    end else begin
      state   <= stateNext;
      byteCnt <= byteCntNext;
      fillCnt <= fillCntNext;
    end
  end

  // R10: a bus reset always lands in idle
  a_r10_bus_reset_idle: assert property (@(posedge clk) disable iff (!rstN)
    busReset |=> (state == ST_IDLE));

  // R6: compare index stays inside the MAC window
  a_r6_cmp_idx_range: assert property (@(posedge clk) disable iff (!rstN)
    ctl.cmpEn |-> (ctl.cmpIdx < MW'(MAC_BYTES)));

  // R4: the fill counter never passes the fill length
  a_r4_fill_span: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_FILL) |-> (fillCnt < FW'(FILL_CYCLES)));
endmodule

// File: rtl/scrpad_dp.sv
module scrpad_dp
  import scrpad_pkg::*;
(
  input  logic          clk,
  input  logic          rstN,
  input  ctl_t          ctl,
  input  logic [7:0]    dataByte,
  input  logic          readSlot,
  output logic          readBit,
  input  logic          loadEn,
  input  logic [AW-1:0] loadAddr,
  input  logic [7:0]    loadData,
  input  logic          flagWr,
  input  logic          hideIn,
  input  logic          authIn,
  input  logic [AW-1:0] peekAddr,
  output logic [7:0]    peekData,
  output logic          hideFlag,
  output logic          authFlag,
  output logic          matchFlag,
  output logic          minReadMet
);
  logic [7:0]    mem [SP_BYTES];
  logic [AW-1:0] cmpAddr;
  logic          mismatch, failReg, failNow, okReg, patPhase;
  logic [CW-1:0] patCount;

  assign peekData   = mem[peekAddr];
  assign cmpAddr    = AW'(MAC_BASE) + AW'(ctl.cmpIdx);
  assign mismatch   = (mem[cmpAddr] != dataByte);
  assign failNow    = failReg | (ctl.cmpEn & mismatch);
  assign minReadMet = (patCount == CW'(MIN_READS));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < SP_BYTES; i++) mem[i] <= '0;
    end else if (ctl.fillWr) begin
      mem[ctl.fillIdx] <= 8'hFF;
    end else if (loadEn) begin
      mem[loadAddr] <= loadData;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      hideFlag  <= 1'b0;
      authFlag  <= 1'b0;
      matchFlag <= 1'b0;
    end else begin
      if (ctl.eraseDone)   hideFlag <= 1'b0;
      else if (flagWr)     hideFlag <= hideIn;
      if (flagWr)          authFlag <= authIn;
      if (ctl.cmpLast && !failNow && authFlag) matchFlag <= 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      failReg <= 1'b0;
      okReg   <= 1'b0;
    end else if (ctl.patClr) begin
      failReg <= 1'b0;
      okReg   <= 1'b0;
    end else begin
      if (ctl.cmpEn)     failReg <= failNow;
      if (ctl.eraseDone) okReg   <= 1'b1;
      if (ctl.cmpLast)   okReg   <= !failNow;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      readBit  <= 1'b1;
      patPhase <= 1'b0;
      patCount <= '0;
    end else if (ctl.patClr) begin
      readBit  <= 1'b1;
      patPhase <= 1'b0;
      patCount <= '0;
    end else if (readSlot) begin
      if (ctl.patActive && okReg) begin
        readBit  <= patPhase;
        patPhase <= ~patPhase;
        if (patCount != CW'(MIN_READS)) patCount <= patCount + CW'(1);
      end else begin
        readBit <= 1'b1;
      end
    end
  end

  // R3: erase completion leaves hide cleared
  a_r3_hide_cleared: assert property (@(posedge clk) disable iff (!rstN)
    ctl.eraseDone |=> !hideFlag);

  // R8: match flag may only rise while authorisation was set
  a_r8_match_needs_auth: assert property (@(posedge clk) disable iff (!rstN)
    $rose(matchFlag) |-> $past(authFlag));

  // R4: outside the completion phase reads give ones
  a_r4_ones_when_inactive: assert property (@(posedge clk) disable iff (!rstN)
    (readSlot && !ctl.patActive && !ctl.patClr) |=> readBit);

  // R9: once met, the minimum stays met until a pattern clear
  a_r9_min_read_sticky: assert property (@(posedge clk) disable iff (!rstN)
    (minReadMet && !ctl.patClr) |=> minReadMet);
endmodule

// File: rtl/scrpad_engine.sv
module scrpad_engine
  import scrpad_pkg::*;
#(
  parameter int CLK_MHZ = 50,
  parameter int FILL_US = 32
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       busReset,
  input  logic       cmdValid,
  input  logic [7:0] cmdCode,
  input  logic       dataValid,
  input  logic [7:0] dataByte,
  input  logic       readSlot,
  output logic       readBit,
  input  logic       loadEn,
  input  logic [4:0] loadAddr,
  input  logic [7:0] loadData,
  input  logic       flagWr,
  input  logic       hideIn,
  input  logic       authIn,
  input  logic [4:0] peekAddr,
  output logic [7:0] peekData,
  output logic       hideFlag,
  output logic       authFlag,
  output logic       matchFlag,
  output logic       minReadMet
);
  localparam int FILL_CYCLES = CLK_MHZ * FILL_US;

  ctl_t ctl;

  scrpad_ctrl #(.FILL_CYCLES(FILL_CYCLES)) uCtrl (
    .clk(clk), .rstN(rstN), .busReset(busReset), .cmdValid(cmdValid),
    .cmdCode(cmdCode), .dataValid(dataValid), .ctl(ctl)
  );

  scrpad_dp uDp (
    .clk(clk), .rstN(rstN), .ctl(ctl), .dataByte(dataByte),
    .readSlot(readSlot), .readBit(readBit), .loadEn(loadEn),
    .loadAddr(loadAddr), .loadData(loadData), .flagWr(flagWr),
    .hideIn(hideIn), .authIn(authIn), .peekAddr(peekAddr),
    .peekData(peekData), .hideFlag(hideFlag), .authFlag(authFlag),
    .matchFlag(matchFlag), .minReadMet(minReadMet)
  );
endmodule

// File: tb/sim_scrpad_engine.sv
module sim_scrpad_engine;
  localparam int FILL = 50 * 32;

  logic clk = 0, rstN = 0, busReset = 0, cmdValid = 0, dataValid = 0;
  logic readSlot = 0, loadEn = 0, flagWr = 0, hideIn = 0, authIn = 0;
  logic [7:0] cmdCode = 0, dataByte = 0, loadData = 0, peekData;
  logic [4:0] loadAddr = 0, peekAddr = 0;
  logic readBit, hideFlag, authFlag, matchFlag, minReadMet;

  int total = 0, bad = 0, cycles = 0;
  bit expQ[$];
  string tagQ[$];

  always #10 clk = ~clk;

  scrpad_engine u0 (.*);

  function automatic logic [7:0] macByte(int i);
    return 8'(i * 7 + 3);
  endfunction

  task automatic chk(bit ok, string req, int act, int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // monitor: pops expected read bits when the design produces them
  always @(posedge clk) begin
    if (readSlot && rstN) begin
      #5;
      if (expQ.size() > 0) begin
        bit e;
        string t;
        e = expQ.pop_front();
        t = tagQ.pop_front();
        chk(readBit == e, t, readBit, e);
      end
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000) begin
      bad++; total++;
      $display("FAIL watchdog actual=%0d expected=%0d", cycles, 20000);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  task automatic rdSlot(bit e, string t);
    @(negedge clk); readSlot = 1; expQ.push_back(e); tagQ.push_back(t);
    @(negedge clk); readSlot = 0;
  endtask

  task automatic sendCmd(logic [7:0] c);
    @(negedge clk); cmdValid = 1; cmdCode = c;
    @(negedge clk); cmdValid = 0;
  endtask

  task automatic sendByte(logic [7:0] b);
    @(negedge clk); dataValid = 1; dataByte = b;
    @(negedge clk); dataValid = 0;
  endtask

  task automatic pulseBusReset();
    @(negedge clk); busReset = 1;
    @(negedge clk); busReset = 0;
  endtask

  task automatic setFlags(bit h, bit a);
    @(negedge clk); flagWr = 1; hideIn = h; authIn = a;
    @(negedge clk); flagWr = 0;
  endtask

  task automatic peek(int a, logic [7:0] e, string t);
    @(negedge clk); peekAddr = 5'(a); #1;
    chk(peekData == e, t, peekData, e);
  endtask

  // badIdx < 0 sends the correct MAC
  task automatic sendMac(int badIdx);
    sendCmd(8'h3C);
    for (int i = 0; i < 20; i++)
      sendByte(i == badIdx ? ~macByte(8 + i) : macByte(8 + i));
  endtask

  task automatic drain();
    repeat (3) @(negedge clk);
  endtask

  initial begin
    repeat (2) @(negedge clk);
    // R1 reset state
    chk(!hideFlag && !authFlag && !matchFlag, "R1 flags", {hideFlag, authFlag, matchFlag}, 0);
    chk(!minReadMet, "R1 minReadMet", minReadMet, 0);
    chk(readBit == 1, "R1 readBit", readBit, 1);
    rstN = 1;
    peek(27, 8'h00, "R1 memory");
    rdSlot(1, "R1 idle read");

    for (int i = 0; i < 32; i++) begin
      @(negedge clk); loadEn = 1; loadAddr = 5'(i); loadData = macByte(i);
    end
    @(negedge clk); loadEn = 0;
    setFlags(1, 0);

    // R11 unknown code ignored
    sendCmd(8'h55);
    sendByte(8'h00);
    rdSlot(1, "R11 unknown code");
    peek(0, macByte(0), "R11 memory kept");

    // R6 correct match, auth clear: R8 flag unchanged
    sendMac(-1);
    for (int i = 0; i < 10; i++) rdSlot(i[0], "R6 pattern");
    drain();
    chk(!matchFlag, "R8 no auth", matchFlag, 0);
    chk(minReadMet, "R9 ten reads", minReadMet, 1);
    chk(hideFlag, "R12 hide kept", hideFlag, 1);
    peek(9, macByte(9), "R12 memory kept");

    // R10 bus reset keeps state, clears count
    pulseBusReset();
    chk(!minReadMet, "R10 count cleared", minReadMet, 0);
    chk(hideFlag, "R10 hide kept", hideFlag, 1);
    peek(20, macByte(20), "R10 memory kept");
    setFlags(1, 1);

    // R7 last byte wrong
    sendMac(19);
    sendCmd(8'hC3);
    for (int i = 0; i < 9; i++) rdSlot(1, "R7 last byte wrong");
    drain();
    chk(!matchFlag, "R8 mismatch", matchFlag, 0);
    chk(!minReadMet, "R9 failed match", minReadMet, 0);
    pulseBusReset();

    // R8 full match with auth
    sendMac(-1);
    for (int i = 0; i < 5; i++) rdSlot(i[0], "R6 pattern auth");
    drain();
    chk(matchFlag, "R8 auth set", matchFlag, 1);
    chk(!minReadMet, "R9 five reads", minReadMet, 0);
    pulseBusReset();

    // R7 first byte wrong, extra byte ignored
    sendMac(0);
    sendByte(8'h11);
    for (int i = 0; i < 4; i++) rdSlot(1, "R7 first byte wrong");
    drain();
    chk(matchFlag, "R8 stays set", matchFlag, 1);
    pulseBusReset();

    // R10 bus reset during erase address phase
    sendCmd(8'hC3);
    sendByte(8'h1A);
    pulseBusReset();
    repeat (40) @(negedge clk);
    peek(3, macByte(3), "R10 erase abandoned");
    chk(hideFlag, "R10 hide after abort", hideFlag, 1);

    // R2 erase
    sendCmd(8'hC3);
    sendByte(8'h1A);
    sendByte(8'h00);
    for (int i = 0; i < 3; i++) rdSlot(1, "R4 busy reads");
    sendCmd(8'h3C);
    rdSlot(1, "R11 busy command");
    chk(hideFlag, "R3 hide before done", hideFlag, 1);
    repeat (FILL) @(negedge clk);
    chk(!hideFlag, "R3 hide cleared", hideFlag, 0);
    for (int i = 0; i < 32; i++) peek(i, 8'hFF, "R2 fill");
    for (int i = 0; i < 8; i++) rdSlot(i[0], "R5 pattern");
    drain();
    chk(minReadMet, "R9 eight reads", minReadMet, 1);
    pulseBusReset();
    chk(!minReadMet, "R10 cleared again", minReadMet, 0);

    drain();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule